// File: doc/BRIEF.md
# Four-List Frame Address Queue Engine

This block keeps four circular lists of 32-bit message-frame addresses for a message unit that sits between a host bus and a local processor. The lists are: frames the host may take for inbound messages (inbound free), inbound messages waiting for the local processor (inbound post), frames the local processor may take for replies (outbound free), and replies waiting for the host (outbound post). Each list has its own producer pointer (head) and consumer pointer (tail) over its own region of an internal queue memory.

The host sees two port addresses. A read of the inbound port takes a free frame, and a write to it posts an inbound message. A read of the outbound port collects a posted reply, and a write to it hands a frame back. The local processor reaches the other end of each list through four data windows. It can also read and overwrite all eight pointers. A control register holds an enable bit and a size code, and a base register places the lists in the address space. Two level flags tell the status logic that an inbound or an outbound post list holds work. A one-cycle pulse per list reports a dropped push.

Top module: `fq_engine`

## Requirements
- R1: After reset the engine is disabled, every list is empty, both not-empty flags and all overflow pulses are low, and both read data outputs are zero.
- R2: A host write to address 0x040 pushes its data onto the inbound post list. A local read of 0x184 pops that list in first-in first-out order, and returns 0xFFFFFFFF when the list is empty.
- R3: A local write to 0x180 pushes onto the inbound free list. A host read of 0x040 pops that list in order, and returns 0xFFFFFFFF when the list is empty.
- R4: A local write to 0x188 pushes onto the outbound post list, and a host read of 0x044 pops it. A host write to 0x044 pushes onto the outbound free list, and a local read of 0x18C pops it. Either pop returns 0xFFFFFFFF on an empty list.
- R5: While the enable bit is clear, every pop returns 0xFFFFFFFF and moves no pointer, and every push is dropped without an overflow pulse.
- R6: Size codes 0x02, 0x04, 0x08, 0x10 and 0x20 give each list 2^(MIN_LG+k) slots for k = 0..4. Any other code acts as 0x02. A list holds at most one entry less than its slot count.
- R7: A push to a full list is dropped, and ovf_pulse[i] is high for exactly the one cycle after it. The list index i is 0 for inbound free, 1 for inbound post, 2 for outbound free and 3 for outbound post.
- R8: Each pointer moves by one 4-byte slot per accepted access and wraps to the start of its list's region. Reading a pointer register returns base | (i << (lg+2)) | (slot << 2), where lg is log2 of the slot count.
- R9: The pointer registers are at 0x120 + 16*i (head) and 0x128 + 16*i (tail). A local write to one of them sets the slot index from write-data bits [MIN_LG+5:2].
- R10: in_post_nempty is high exactly when the inbound post list is non-empty, and out_post_nempty is high exactly when the outbound post list is non-empty. Both are level signals.
- R11: The base register at 0x170 keeps write bits [31:20] and reads zero below them. The control register at 0x164 keeps the enable in bit 0 and the size code in bits [13:8], and reads back in that format.
- R12: Read data is registered. It appears on host_rdata or loc_rdata the cycle after the read strobe and holds until the next read on that side. Reads of unmapped addresses return zero.
- R13: A host access and a local access to the same list in one cycle both take effect, because one moves the head and the other moves the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 12 | Host byte address (0x040 inbound port, 0x044 outbound port) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| loc_rd | input | 1 | Local read strobe |
| loc_wr | input | 1 | Local write strobe |
| loc_addr | input | 12 | Local byte address |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Registered local read data |
| in_post_nempty | output | 1 | Inbound post list holds entries |
| out_post_nempty | output | 1 | Outbound post list holds entries |
| ovf_pulse | output | 4 | One-cycle dropped-push pulse per list |

## Verification
The assertions assume that each side issues at most one strobe per cycle, so that read and write on a side are never raised together. They also assume that a strobe's address is stable in the cycle it is sampled. The directed tasks meet both assumptions: every task raises a single strobe for exactly one cycle, between falling edges, with its address already set. The one scenario that drives both sides at once combines a host write and a local read on the same list.

// File: rtl/fq_pkg.sv
package fq_pkg;

  localparam int NLISTS = 4;
  localparam int DW     = 32;
  localparam int AW     = 12;

  // list indices; the pointer register map and ovf_pulse bits follow this order
  localparam int L_IF = 0;  // inbound free
  localparam int L_IP = 1;  // inbound post
  localparam int L_OF = 2;  // outbound free
  localparam int L_OP = 3;  // outbound post

  // which lists take their pushes from the host side
  localparam logic [NLISTS-1:0] HOST_PRODUCES = 4'b0110;

  localparam logic [AW-1:0] A_IN_PORT  = 12'h040;
  localparam logic [AW-1:0] A_OUT_PORT = 12'h044;
  localparam logic [AW-1:0] A_PTR_LO   = 12'h120;
  localparam logic [AW-1:0] A_PTR_HI   = 12'h158;
  localparam logic [AW-1:0] A_CTRL     = 12'h164;
  localparam logic [AW-1:0] A_BASE     = 12'h170;
  localparam logic [AW-1:0] A_IF_PUSH  = 12'h180;
  localparam logic [AW-1:0] A_IP_POP   = 12'h184;
  localparam logic [AW-1:0] A_OP_PUSH  = 12'h188;
  localparam logic [AW-1:0] A_OF_POP   = 12'h18C;

  localparam logic [DW-1:0] NO_FRAME = 32'hFFFF_FFFF;

  // size code to a step of 0..4; unlisted codes fall back to the smallest size
  function automatic logic [2:0] size_step(input logic [5:0] code);
    case (code)
      6'h04:   size_step = 3'd1;
      6'h08:   size_step = 3'd2;
      6'h10:   size_step = 3'd3;
      6'h20:   size_step = 3'd4;
      default: size_step = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/fq_cfg.sv
module fq_cfg
  import fq_pkg::*;
#(
  parameter int MIN_LG = 2,
  parameter int IDXW   = MIN_LG + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_base,
  input  logic [DW-1:0]   wdata,
  output logic            en,
  output logic [5:0]      code,
  output logic [11:0]     base_hi,
  output logic [4:0]      lg,
  output logic [IDXW-1:0] mask
);

  logic        en_d;
  logic [5:0]  code_d;
  logic [11:0] base_d;

  always_comb begin
    en_d   = en;
    code_d = code;
    base_d = base_hi;
    if (wr_ctrl) begin
      en_d   = wdata[0];
      code_d = wdata[13:8];
    end
    if (wr_base) begin
      base_d = wdata[31:20];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      code    <= 6'h00;
      base_hi <= 12'h000;
    end else begin
      en      <= en_d;
      code    <= code_d;
      base_hi <= base_d;
    end
  end

  always_comb begin
    lg   = 5'(MIN_LG) + {2'b00, size_step(code)};
    mask = IDXW'((32'd1 << lg) - 32'd1);
  end

endmodule

// File: rtl/fq_decode.sv
module fq_decode
  import fq_pkg::*;
(
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [AW-1:0]     host_addr,
  input  logic              loc_rd,
  input  logic              loc_wr,
  input  logic [AW-1:0]     loc_addr,
  output logic [NLISTS-1:0] push,
  output logic [NLISTS-1:0] pop,
  output logic [NLISTS-1:0] set_head,
  output logic [NLISTS-1:0] set_tail,
  output logic              ptr_hit,
  output logic [1:0]        ptr_list,
  output logic              ptr_tail,
  output logic              wr_ctrl,
  output logic              wr_base
);

  logic [AW-1:0] off;

  always_comb begin
    off      = loc_addr - A_PTR_LO;
    ptr_hit  = (loc_addr >= A_PTR_LO) && (loc_addr <= A_PTR_HI) && (off[2:0] == 3'b000);
    ptr_list = off[5:4];
    ptr_tail = off[3];

    push       = '0;
    push[L_IF] = loc_wr  && (loc_addr  == A_IF_PUSH);
    push[L_IP] = host_wr && (host_addr == A_IN_PORT);
    push[L_OF] = host_wr && (host_addr == A_OUT_PORT);
    push[L_OP] = loc_wr  && (loc_addr  == A_OP_PUSH);

    pop       = '0;
    pop[L_IF] = host_rd && (host_addr == A_IN_PORT);
    pop[L_IP] = loc_rd  && (loc_addr  == A_IP_POP);
    pop[L_OF] = loc_rd  && (loc_addr  == A_OF_POP);
    pop[L_OP] = host_rd && (host_addr == A_OUT_PORT);

    for (int l = 0; l < NLISTS; l++) begin
      set_head[l] = loc_wr && ptr_hit && (ptr_list == 2'(l)) && !ptr_tail;
      set_tail[l] = loc_wr && ptr_hit && (ptr_list == 2'(l)) &&  ptr_tail;
    end

    wr_ctrl = loc_wr && (loc_addr == A_CTRL);
    wr_base = loc_wr && (loc_addr == A_BASE);
  end

endmodule

// File: rtl/fq_list.sv
module fq_list #(
  parameter int IDXW = 6,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [IDXW-1:0] mask,
  input  logic            push,
  input  logic [DW-1:0]   push_data,
  input  logic            pop,
  input  logic            set_head,
  input  logic            set_tail,
  input  logic [IDXW-1:0] set_idx,
  output logic [IDXW-1:0] head,
  output logic [IDXW-1:0] tail,
  output logic            empty,
  output logic            full,
  output logic [DW-1:0]   pop_data,
  output logic            ovf
);

  localparam int DEPTH = 1 << IDXW;

  logic [IDXW-1:0] head_q, tail_q, head_d, tail_d;
  logic [DW-1:0]   mem [DEPTH];
  logic            push_ok, pop_ok;

  always_comb begin
    head     = head_q & mask;
    tail     = tail_q & mask;
    empty    = (head == tail);
    full     = (((head + 1'b1) & mask) == tail);
    push_ok  = en && push && !full;
    pop_ok   = en && pop && !empty;
    ovf      = en && push && full;
    pop_data = (en && !empty) ? mem[tail] : {DW{1'b1}};

    head_d = head_q;
    if (set_head)     head_d = set_idx;
    else if (push_ok) head_d = (head + 1'b1) & mask;

    tail_d = tail_q;
    if (set_tail)    tail_d = set_idx;
    else if (pop_ok) tail_d = (tail + 1'b1) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[head] <= push_data;
  end

endmodule

// File: rtl/fq_engine.sv
module fq_engine
  import fq_pkg::*;
#(
  parameter int MIN_LG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [11:0]   host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          loc_rd,
  input  logic          loc_wr,
  input  logic [11:0]   loc_addr,
  input  logic [31:0]   loc_wdata,
  output logic [31:0]   loc_rdata,
  output logic          in_post_nempty,
  output logic          out_post_nempty,
  output logic [3:0]    ovf_pulse
);

  localparam int IDXW = MIN_LG + 4;

  logic              en;
  logic [5:0]        code;
  logic [11:0]       base_hi;
  logic [4:0]        lg;
  logic [IDXW-1:0]   mask;
  logic [NLISTS-1:0] push, pop, set_head, set_tail;
  logic              ptr_hit, ptr_tail, wr_ctrl, wr_base;
  logic [1:0]        ptr_list;
  logic [NLISTS-1:0] list_empty, list_full, list_ovf;
  logic [IDXW-1:0]   head_w [NLISTS];
  logic [IDXW-1:0]   tail_w [NLISTS];
  logic [DW-1:0]     pop_w  [NLISTS];

  logic [DW-1:0]     host_rdata_d, loc_rdata_d, ptr_val;
  logic [3:0]        ovf_d;

  fq_cfg #(.MIN_LG(MIN_LG), .IDXW(IDXW)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_base(wr_base),
    .wdata(loc_wdata), .en(en), .code(code), .base_hi(base_hi),
    .lg(lg), .mask(mask)
  );

  fq_decode dec_i (
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_addr(loc_addr),
    .push(push), .pop(pop), .set_head(set_head), .set_tail(set_tail),
    .ptr_hit(ptr_hit), .ptr_list(ptr_list), .ptr_tail(ptr_tail),
    .wr_ctrl(wr_ctrl), .wr_base(wr_base)
  );

  for (genvar g = 0; g < NLISTS; g++) begin : g_list
    logic [DW-1:0] pdata;
    assign pdata = HOST_PRODUCES[g] ? host_wdata : loc_wdata;

    fq_list #(.IDXW(IDXW), .DW(DW)) list_i (
      .clk(clk), .rst_n(rst_n), .en(en), .mask(mask),
      .push(push[g]), .push_data(pdata), .pop(pop[g]),
      .set_head(set_head[g]), .set_tail(set_tail[g]),
      .set_idx(loc_wdata[IDXW+1:2]),
      .head(head_w[g]), .tail(tail_w[g]),
      .empty(list_empty[g]), .full(list_full[g]),
      .pop_data(pop_w[g]), .ovf(list_ovf[g])
    );
  end

  // pointer register view: base | list region | slot offset
  always_comb begin
    logic [IDXW-1:0] idx;
    idx     = ptr_tail ? tail_w[ptr_list] : head_w[ptr_list];
    ptr_val = {base_hi, 20'h00000}
            | (32'(ptr_list) << (lg + 5'd2))
            | (32'(idx) << 2);
  end

  always_comb begin
    host_rdata_d = host_rdata;
    if (host_rd) begin
      case (host_addr)
        A_IN_PORT:  host_rdata_d = pop_w[L_IF];
        A_OUT_PORT: host_rdata_d = pop_w[L_OP];
        default:    host_rdata_d = '0;
      endcase
    end

    loc_rdata_d = loc_rdata;
    if (loc_rd) begin
      if (ptr_hit) begin
        loc_rdata_d = ptr_val;
      end else begin
        case (loc_addr)
          A_CTRL:   loc_rdata_d = {18'h0, code, 7'h00, en};
          A_BASE:   loc_rdata_d = {base_hi, 20'h00000};
          A_IP_POP: loc_rdata_d = pop_w[L_IP];
          A_OF_POP: loc_rdata_d = pop_w[L_OF];
          default:  loc_rdata_d = '0;
        endcase
      end
    end

    ovf_d = list_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      loc_rdata  <= '0;
      ovf_pulse  <= '0;
    end else begin
      host_rdata <= host_rdata_d;
      loc_rdata  <= loc_rdata_d;
      ovf_pulse  <= ovf_d;
    end
  end

  assign in_post_nempty  = !list_empty[L_IP];
  assign out_post_nempty = !list_empty[L_OP];

endmodule

// File: rtl/fq_engine_chk.sv
module fq_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_rd,
  input logic        host_wr,
  input logic [11:0] host_addr,
  input logic [31:0] host_rdata,
  input logic        loc_rd,
  input logic        loc_wr,
  input logic [11:0] loc_addr,
  input logic [31:0] loc_rdata,
  input logic        in_post_nempty,
  input logic        out_post_nempty,
  input logic [3:0]  ovf_pulse,
  input logic        en,
  input logic [3:0]  list_empty
);

  assert_empty_pop_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 12'h040 && list_empty[0]) |=> (host_rdata == 32'hFFFF_FFFF));

  assert_disabled_pop_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && host_rd && host_addr == 12'h044) |=> (host_rdata == 32'hFFFF_FFFF));

  assert_ovf_needs_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse != 4'h0) |-> $past(host_wr || loc_wr));

  assert_ip_ovf_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse[1] |-> $past(host_wr && host_addr == 12'h040));

  assert_inpost_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_post_nempty) |-> $past(host_wr || loc_wr));

  assert_outpost_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_post_nempty) |-> $past(host_rd || loc_wr));

  assert_base_low_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_rd && loc_addr == 12'h170) |=> (loc_rdata[19:0] == 20'h0));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

endmodule

bind fq_engine fq_engine_chk chk_i (.*);

// File: tb/fq_engine_tb_top.sv
`timescale 1ns/1ps
module fq_engine_tb_top;

  logic        clk, rst_n;
  logic        host_rd, host_wr, loc_rd, loc_wr;
  logic [11:0] host_addr, loc_addr;
  logic [31:0] host_wdata, loc_wdata;
  logic [31:0] host_rdata, loc_rdata;
  logic        in_post_nempty, out_post_nempty;
  logic [3:0]  ovf_pulse;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  fq_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .in_post_nempty(in_post_nempty), .out_post_nempty(out_post_nempty),
    .ovf_pulse(ovf_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic host_write(input logic [11:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [11:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic loc_write(input logic [11:0] a, input logic [31:0] d);
    loc_wr = 1'b1; loc_addr = a; loc_wdata = d;
    @(negedge clk);
    loc_wr = 1'b0;
  endtask

  task automatic loc_read(input logic [11:0] a, output logic [31:0] d);
    loc_rd = 1'b1; loc_addr = a;
    @(negedge clk);
    loc_rd = 1'b0;
    d = loc_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 host_rdata", host_rdata, 32'h0);
    chk("R1 loc_rdata", loc_rdata, 32'h0);
    chk("R1 flags", {30'h0, in_post_nempty, out_post_nempty}, 32'h0);
    chk("R1 ovf", {28'h0, ovf_pulse}, 32'h0);
    loc_read(12'h164, v);
    chk("R1 ctrl", v, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    host_read(12'h040, v);
    chk("R5 pop disabled", v, 32'hFFFF_FFFF);
    host_write(12'h040, 32'h1111);
    chk("R5 push dropped flag", {31'h0, in_post_nempty}, 32'h0);
    chk("R5 no ovf", {28'h0, ovf_pulse}, 32'h0);
    loc_read(12'h130, v);
    chk("R5 head unchanged", v, 32'h0000_0010);
    loc_read(12'h18C, v);
    chk("R5 local pop disabled", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_config();
    logic [31:0] v;
    loc_write(12'h170, 32'hABC1_2345);
    loc_read(12'h170, v);
    chk("R11 base", v, 32'hABC0_0000);
    loc_write(12'h164, 32'h0000_0201);
    loc_read(12'h164, v);
    chk("R11 ctrl", v, 32'h0000_0201);
    loc_read(12'h1F0, v);
    chk("R12 unmapped", v, 32'h0);
  endtask

  task automatic t_inbound();
    logic [31:0] v;
    loc_write(12'h180, 32'h0000_A000);
    loc_write(12'h180, 32'h0000_B000);
    host_read(12'h040, v);
    chk("R3 first free", v, 32'h0000_A000);
    idle();
    chk("R12 hold", host_rdata, 32'h0000_A000);
    host_read(12'h040, v);
    chk("R3 second free", v, 32'h0000_B000);
    host_read(12'h040, v);
    chk("R3 empty free", v, 32'hFFFF_FFFF);
    host_write(12'h040, 32'h0000_C000);
    host_write(12'h040, 32'h0000_D000);
    chk("R10 in flag set", {31'h0, in_post_nempty}, 32'h1);
    loc_read(12'h184, v);
    chk("R2 first post", v, 32'h0000_C000);
    loc_read(12'h184, v);
    chk("R2 second post", v, 32'h0000_D000);
    chk("R10 in flag clear", {31'h0, in_post_nempty}, 32'h0);
    loc_read(12'h184, v);
    chk("R2 empty post", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_outbound();
    logic [31:0] v;
    loc_write(12'h188, 32'h0000_E000);
    chk("R10 out flag set", {31'h0, out_post_nempty}, 32'h1);
    host_read(12'h044, v);
    chk("R4 reply pop", v, 32'h0000_E000);
    chk("R10 out flag clear", {31'h0, out_post_nempty}, 32'h0);
    host_read(12'h044, v);
    chk("R4 reply empty", v, 32'hFFFF_FFFF);
    host_write(12'h044, 32'h0000_F000);
    loc_read(12'h18C, v);
    chk("R4 free return pop", v, 32'h0000_F000);
    loc_read(12'h18C, v);
    chk("R4 free empty", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    for (int i = 1; i <= 3; i++) host_write(12'h040, 32'(i * 32'h100));
    chk("R7 no ovf at cap-1", {28'h0, ovf_pulse}, 32'h0);
    host_write(12'h040, 32'h0000_0400);
    chk("R7 ovf pulse", {28'h0, ovf_pulse}, 32'h2);
    idle();
    chk("R7 ovf one cycle", {28'h0, ovf_pulse}, 32'h0);
    for (int i = 1; i <= 3; i++) begin
      loc_read(12'h184, v);
      chk("R7 kept order", v, 32'(i * 32'h100));
    end
    loc_read(12'h184, v);
    chk("R7 dropped push", v, 32'hFFFF_FFFF);
    loc_read(12'h130, v);
    chk("R8 head wrapped", v, 32'hABC0_0014);
    loc_read(12'h138, v);
    chk("R8 tail wrapped", v, 32'hABC0_0014);
  endtask

  task automatic t_size();
    logic [31:0] v;
    loc_write(12'h164, 32'h0000_0801);
    for (int i = 0; i < 15; i++) host_write(12'h044, 32'h1000 + 32'(i));
    chk("R6 15 fit", {28'h0, ovf_pulse}, 32'h0);
    host_write(12'h044, 32'h0000_2000);
    chk("R6 16th overflows", {28'h0, ovf_pulse}, 32'h4);
    loc_read(12'h140, v);
    chk("R8 region for code 08", v, 32'hABC0_0080);
    for (int i = 0; i < 15; i++) begin
      loc_read(12'h18C, v);
      chk("R6 order", v, 32'h1000 + 32'(i));
    end
    loc_read(12'h18C, v);
    chk("R6 drained", v, 32'hFFFF_FFFF);
    loc_write(12'h164, 32'h0000_0301);
    loc_read(12'h140, v);
    chk("R6 bad code as 02", v, 32'hABC0_0020);
  endtask

  task automatic t_ptr();
    logic [31:0] v;
    loc_write(12'h130, 32'h0000_000C);
    chk("R9 head set", {31'h0, in_post_nempty}, 32'h1);
    loc_read(12'h130, v);
    chk("R9 head readback", v, 32'hABC0_001C);
    loc_write(12'h138, 32'h0000_000C);
    chk("R9 tail set", {31'h0, in_post_nempty}, 32'h0);
  endtask

  task automatic t_concurrent();
    logic [31:0] v;
    host_write(12'h040, 32'h0000_5555);
    host_wr = 1'b1; host_addr = 12'h040; host_wdata = 32'h0000_6666;
    loc_rd  = 1'b1; loc_addr  = 12'h184;
    @(negedge clk);
    host_wr = 1'b0; loc_rd = 1'b0;
    chk("R13 pop same cycle", loc_rdata, 32'h0000_5555);
    loc_read(12'h184, v);
    chk("R13 push same cycle", v, 32'h0000_6666);
    chk("R13 flag after", {31'h0, in_post_nempty}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    host_rd = 0; host_wr = 0; loc_rd = 0; loc_wr = 0;
    host_addr = '0; loc_addr = '0; host_wdata = '0; loc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_config();
    t_inbound();
    t_outbound();
    t_overflow();
    t_size();
    t_ptr();
    t_concurrent();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule